// File: doc/BRIEF.md
# Multi-Channel Tick Timer

This block is a small memory-mapped timer peripheral with four event timers and one free-running timestamp counter. A shared prescaler turns the system clock into four tick strobes of 1 µs, 10 µs, 100 µs and 1 ms. Each event timer picks one of these strobes. It counts down from a programmed load value and raises a one-cycle interrupt pulse on expiry. In periodic mode it then reloads and keeps running. In one-shot mode it stops and clears its own enable bit.

The timestamp counter counts upward and wraps. Its source is either the raw system clock or one of the four tick strobes. Software reads it as a monotonic time base. All configuration lives in one control word. Each event timer has a word that is written with its load value and read back as its remaining count.

The bus port is a plain single-cycle word interface. The word index is byte offset divided by four. Writes take effect on the clock edge where the write strobe is high. Read data is combinational from the word index.

Top module: `multi_tick_timer`

## Requirements
- R1: While reset is asserted the control word reads 0, every event count reads 0, the timestamp reads 0, and all interrupt outputs are low.
- R2: In the control word (word 0), bits 19:16 are the enables of timers A to D, bits 15:12 their modes (1 = periodic, 0 = one-shot), bits 10:8 the timestamp source, and bits 1:0, 3:2, 5:4 and 7:6 the rate codes of A, B, C and D. Bit 11 and bits 31:20 read 0.
- R3: Rate code 0, 1, 2 and 3 gives a tick every US, 10·US, 100·US and 1000·US system clocks. Here US is CLK_PER_US and the factor 10 is the DECADE parameter.
- R4: After load value N is written (timer A at word 1, B at 2, C at 3, D at 4), setting the timer's enable bit makes it expire after N+1 of its ticks. Each expiry gives a single-cycle high pulse on irq (bit 0 = A, bit 3 = D).
- R5: In periodic mode the timer reloads N on every expiry. Consecutive pulses are therefore exactly (N+1) tick periods apart.
- R6: In one-shot mode the expiry clears the timer's enable bit and leaves its mode and rate bits unchanged. No further pulse follows.
- R7: Clearing a timer's enable bit freezes its count and stops its pulses.
- R8: A timer's word reads back its remaining count, zero-extended. A load value written while the timer is disabled is copied into the count on the enable edge.
- R9: The timestamp (word 5) adds one on every system clock for source code 0. For codes 1 to 4 it adds one per tick of 1 µs, 10 µs, 100 µs and 1 ms respectively. Codes 5 to 7 hold it.
- R10: The timestamp wraps modulo 2^STAMP_W. Bus writes to word 5 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_word | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq | output | 4 | Expiry pulses of timers A (bit 0) to D (bit 3) |

## Verification
The bench builds the block with CLK_PER_US = 2 and DECADE = 3. This makes the slowest tick 54 clocks, so every rate code and several periodic intervals fit in a short run. STAMP_W = 8 lets the timestamp wrap within a few hundred clocks, which brings R10 within reach. CNT_W stays at 16, so load values are held in the full count width.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
   localparam int unsigned NUM_EVT   = 4;
   localparam int unsigned RATE_W    = 2;
   localparam int unsigned NUM_RATE  = 4;
   localparam int unsigned SSEL_W    = 3;
   localparam int unsigned EN_LSB    = 16;
   localparam int unsigned MODE_LSB  = 12;
   localparam int unsigned SSEL_LSB  = 8;
   localparam int unsigned WORD_W    = 3;
   localparam logic [WORD_W-1:0] WORD_CTRL  = 3'd0;
   localparam logic [WORD_W-1:0] WORD_STAMP = 3'd5;

   typedef enum logic [RATE_W-1:0] {
      RATE_1US   = 2'd0,
      RATE_10US  = 2'd1,
      RATE_100US = 2'd2,
      RATE_1MS   = 2'd3
   } rate_e;

   typedef struct packed {
      logic [NUM_EVT-1:0]         en;
      logic [NUM_EVT-1:0]         periodic;
      logic [SSEL_W-1:0]          stamp_src;
      logic [NUM_EVT*RATE_W-1:0]  rate;
   } ctrl_t;

   function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
      logic [31:0] w;
      w = '0;
      w[EN_LSB   +: NUM_EVT] = c.en;
      w[MODE_LSB +: NUM_EVT] = c.periodic;
      w[SSEL_LSB +: SSEL_W]  = c.stamp_src;
      w[0 +: NUM_EVT*RATE_W] = c.rate;
      return w;
   endfunction

   function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
      ctrl_t c;
      c.en        = w[EN_LSB   +: NUM_EVT];
      c.periodic  = w[MODE_LSB +: NUM_EVT];
      c.stamp_src = w[SSEL_LSB +: SSEL_W];
      c.rate      = w[0 +: NUM_EVT*RATE_W];
      return c;
   endfunction
endpackage

// File: rtl/mtt_prescaler.sv
module mtt_prescaler #(
   parameter int unsigned CLK_PER_US = 100,
   parameter int unsigned DECADE     = 10,
   parameter int unsigned NUM_RATE   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_RATE-1:0] tick
);
   localparam int unsigned US_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam int unsigned DEC_W = (DECADE > 1) ? $clog2(DECADE) : 1;
   localparam logic [US_W-1:0]  US_LAST  = US_W'(CLK_PER_US - 1);
   localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECADE - 1);

   logic [US_W-1:0] us_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                us_cnt <= '0;
      else if (us_cnt == US_LAST) us_cnt <= '0;
      else                       us_cnt <= us_cnt + 1'b1;
   end

   assign tick[0] = (us_cnt == US_LAST);

   for (genvar s = 1; s < NUM_RATE; s++) begin : g_stage
      logic [DEC_W-1:0] dec_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dec_cnt <= '0;
         else if (tick[s-1]) begin
            if (dec_cnt == DEC_LAST) dec_cnt <= '0;
            else                     dec_cnt <= dec_cnt + 1'b1;
         end
      end
      assign tick[s] = tick[s-1] && (dec_cnt == DEC_LAST);
   end
endmodule

// File: rtl/mtt_channel.sv
module mtt_channel #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             tick,
   input  logic             periodic,
   input  logic [CNT_W-1:0] load,
   output logic [CNT_W-1:0] count,
   output logic             expire,
   output logic             irq
);
   logic at_zero;
   assign at_zero = (count == '0);
   assign expire  = run && !start && tick && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= expire;
         if (start)
            count <= load;
         else if (run && tick) begin
            if (!at_zero)      count <= count - 1'b1;
            else if (periodic) count <= load;
         end
      end
   end
endmodule

// File: rtl/mtt_stamp.sv
module mtt_stamp #(
   parameter int unsigned STAMP_W  = 32,
   parameter int unsigned SSEL_W   = 3,
   parameter int unsigned NUM_RATE = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SSEL_W-1:0]   sel,
   input  logic [NUM_RATE-1:0] tick,
   output logic [STAMP_W-1:0]  value,
   output logic                step
);
   always_comb begin
      step = 1'b0;
      if (sel == '0)
         step = 1'b1;
      else
         for (int r = 0; r < NUM_RATE; r++)
            if (sel == SSEL_W'(r + 1)) step = tick[r];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (step) value <= value + 1'b1;
   end
endmodule

// File: rtl/multi_tick_timer.sv
module multi_tick_timer
   import mtt_pkg::*;
#(
   parameter int unsigned CLK_PER_US = 100,
   parameter int unsigned DECADE     = 10,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned STAMP_W    = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [2:0]  bus_word,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic [3:0]  irq
);
   if (CLK_PER_US < 2) begin : g_bad_us
      $error("CLK_PER_US must be at least 2");
   end
   if (DECADE < 2) begin : g_bad_dec
      $error("DECADE must be at least 2");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must be within 2..32");
   end
   if (STAMP_W < 2 || STAMP_W > 32) begin : g_bad_stamp
      $error("STAMP_W must be within 2..32");
   end

   ctrl_t                ctrl_q;
   ctrl_t                ctrl_wr_val;
   logic                 ctrl_wr;
   logic [NUM_RATE-1:0]  tick;
   logic [NUM_EVT-1:0]   chan_tick;
   logic [NUM_EVT-1:0]   start;
   logic [NUM_EVT-1:0]   expire;
   logic [CNT_W-1:0]     load_q  [NUM_EVT];
   logic [CNT_W-1:0]     count   [NUM_EVT];
   logic [STAMP_W-1:0]   stamp;
   logic                 stamp_step;

   assign ctrl_wr     = bus_wr && (bus_word == WORD_CTRL);
   assign ctrl_wr_val = word_to_ctrl(bus_wdata);

   mtt_prescaler #(
      .CLK_PER_US(CLK_PER_US),
      .DECADE    (DECADE),
      .NUM_RATE  (NUM_RATE)
   ) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (ctrl_wr)
         ctrl_q <= ctrl_wr_val;
      else
         ctrl_q.en <= ctrl_q.en & ~(expire & ~ctrl_q.periodic);
   end

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_chan
      localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(i + 1);

      assign start[i]     = ctrl_wr && ctrl_wr_val.en[i] && !ctrl_q.en[i];
      assign chan_tick[i] = tick[ctrl_q.rate[i*RATE_W +: RATE_W]];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             load_q[i] <= '0;
         else if (bus_wr && bus_word == MY_WORD) load_q[i] <= bus_wdata[CNT_W-1:0];
      end

      mtt_channel #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .start   (start[i]),
         .run     (ctrl_q.en[i]),
         .tick    (chan_tick[i]),
         .periodic(ctrl_q.periodic[i]),
         .load    (load_q[i]),
         .count   (count[i]),
         .expire  (expire[i]),
         .irq     (irq[i])
      );
   end

   mtt_stamp #(
      .STAMP_W (STAMP_W),
      .SSEL_W  (SSEL_W),
      .NUM_RATE(NUM_RATE)
   ) u_stamp (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (ctrl_q.stamp_src),
      .tick (tick),
      .value(stamp),
      .step (stamp_step)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_word == WORD_CTRL)
         bus_rdata = ctrl_to_word(ctrl_q);
      else if (bus_word == WORD_STAMP)
         bus_rdata = 32'(stamp);
      else
         for (int i = 0; i < NUM_EVT; i++)
            if (bus_word == WORD_W'(i + 1)) bus_rdata = 32'(count[i]);
   end
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
   parameter int unsigned STAMP_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [3:0]         irq,
   input logic [3:0]         en,
   input logic [3:0]         per,
   input logic               ctrl_wr,
   input logic [3:0]         tick,
   input logic [STAMP_W-1:0] stamp,
   input logic               stamp_step
);
   for (genvar i = 0; i < 4; i++) begin : g_ch
      assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |=> !irq[i]);
      assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> $past(en[i]));
      assert_oneshot_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (irq[i] && !per[i] && !$past(ctrl_wr)) |-> !en[i]);
   end

   for (genvar s = 1; s < 4; s++) begin : g_tk
      assert_tick_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
         tick[s] |-> tick[s-1]);
   end

   assert_stamp_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_step |=> (stamp == STAMP_W'($past(stamp) + 1'b1)));
   assert_stamp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !stamp_step |=> $stable(stamp));
endmodule

bind multi_tick_timer mtt_checker #(.STAMP_W(STAMP_W)) u_mtt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .en        (ctrl_q.en),
   .per       (ctrl_q.periodic),
   .ctrl_wr   (ctrl_wr),
   .tick      (tick),
   .stamp     (stamp),
   .stamp_step(stamp_step)
);

// File: tb/multi_tick_timer_bench.sv
module multi_tick_timer_bench;
   localparam int unsigned CLK_PER_US = 2;
   localparam int unsigned DECADE     = 3;
   localparam int unsigned CNT_W      = 16;
   localparam int unsigned STAMP_W    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_word = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int pulse_cnt [4];
   int last_cyc  [4];
   int prev_cyc  [4];
   bit done = 1'b0;

   multi_tick_timer #(
      .CLK_PER_US(CLK_PER_US),
      .DECADE    (DECADE),
      .CNT_W     (CNT_W),
      .STAMP_W   (STAMP_W)
   ) u_multi_tick_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_word (bus_word),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq      (irq)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   initial for (int i = 0; i < 4; i++) begin
      pulse_cnt[i] = 0; last_cyc[i] = 0; prev_cyc[i] = 0;
   end

   always @(negedge clk)
      for (int i = 0; i < 4; i++)
         if (irq[i]) begin
            pulse_cnt[i] = pulse_cnt[i] + 1;
            prev_cyc[i]  = last_cyc[i];
            last_cyc[i]  = cyc;
         end

   function automatic int tick_period(input int code);
      int p;
      p = CLK_PER_US;
      for (int k = 0; k < code; k++) p = p * DECADE;
      return p;
   endfunction

   function automatic logic [31:0] mk_ctrl(input logic [3:0] en, input logic [3:0] per,
                                           input logic [2:0] src, input logic [7:0] rate);
      return {12'b0, en, per, 1'b0, src, rate};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] w, input logic [31:0] d);
      @(negedge clk);
      bus_word = w; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] w, output logic [31:0] d);
      bus_word = w;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_pulses(input int ch, input int target);
      while (pulse_cnt[ch] < target) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      repeat (3) @(negedge clk);
      bus_read(3'd0, d); check(d == 0, "R1 ctrl", d, 0);
      for (int i = 1; i <= 4; i++) begin
         bus_read(3'(i), d); check(d == 0, "R1 count", d, 0);
      end
      bus_read(3'd5, d); check(d == 0, "R1 stamp", d, 0);
      check(irq == 0, "R1 irq", irq, 0);
   endtask

   task automatic t_layout();
      logic [31:0] d;
      bus_write(3'd0, 32'hFFF0_FFFF);
      bus_read(3'd0, d); check(d == 32'h0000_F7FF, "R2 layout", d, 32'h0000_F7FF);
      bus_write(3'd0, 32'h0);
      bus_read(3'd0, d); check(d == 0, "R2 clear", d, 0);
   endtask

   task automatic t_stamp_rates();
      logic [31:0] v0, v1;
      int k, exp;
      for (int code = 0; code <= 5; code++) begin
         bus_write(3'd0, mk_ctrl(4'h0, 4'h0, 3'(code), 8'h00));
         k = (code == 0) ? 5 : ((code <= 4) ? 5 * tick_period(code - 1) : 40);
         exp = (code <= 4) ? 5 : 0;
         bus_read(3'd5, v0);
         repeat (k) @(negedge clk);
         bus_read(3'd5, v1);
         check(8'(v1 - v0) == 8'(exp), "R9 stamp rate", 8'(v1 - v0), exp);
      end
   endtask

   task automatic t_stamp_wrap();
      logic [31:0] v0, v1;
      bus_write(3'd0, mk_ctrl(4'h0, 4'h0, 3'd0, 8'h00));
      bus_read(3'd5, v0);
      repeat (300) @(negedge clk);
      bus_read(3'd5, v1);
      check(v1 == 32'(8'(v0 + 300)), "R10 wrap", v1, 8'(v0 + 300));
      check(v1 < 256, "R10 width", v1, 255);
      bus_write(3'd0, mk_ctrl(4'h0, 4'h0, 3'd5, 8'h00));
      bus_read(3'd5, v0);
      bus_write(3'd5, ~v0);
      bus_read(3'd5, v1);
      check(v1 == v0, "R10 write ignored", v1, v0);
   endtask

   task automatic t_periodic(input int ch, input int code, input int n);
      int base, exp;
      logic [7:0] rate;
      rate = 8'(code) << (2 * ch);
      bus_write(3'(ch + 1), 32'(n));
      base = pulse_cnt[ch];
      bus_write(3'd0, mk_ctrl(4'(1 << ch), 4'(1 << ch), 3'd5, rate));
      wait_pulses(ch, base + 3);
      exp = (n + 1) * tick_period(code);
      check(last_cyc[ch] - prev_cyc[ch] == exp, "R5 R3 periodic interval",
            last_cyc[ch] - prev_cyc[ch], exp);
   endtask

   task automatic t_stop();
      logic [31:0] c0, c1;
      int p0;
      bus_write(3'd0, mk_ctrl(4'h0, 4'h1, 3'd5, 8'h00));
      p0 = pulse_cnt[0];
      bus_read(3'd1, c0);
      repeat (100) @(negedge clk);
      bus_read(3'd1, c1);
      check(pulse_cnt[0] == p0, "R7 no pulse", pulse_cnt[0], p0);
      check(c1 == c0, "R7 count frozen", c1, c0);
   endtask

   task automatic t_oneshot();
      logic [31:0] d;
      int cw, base, dt;
      bus_write(3'd4, 32'd4);
      base = pulse_cnt[3];
      bus_write(3'd0, mk_ctrl(4'h8, 4'h0, 3'd5, 8'h00));
      cw = cyc;
      wait_pulses(3, base + 1);
      dt = last_cyc[3] - cw;
      check(dt >= 9 && dt <= 10, "R4 oneshot delay", dt, 9);
      bus_read(3'd0, d);
      check(d == mk_ctrl(4'h0, 4'h0, 3'd5, 8'h00), "R6 enable cleared", d,
            mk_ctrl(4'h0, 4'h0, 3'd5, 8'h00));
      repeat (100) @(negedge clk);
      check(pulse_cnt[3] == base + 1, "R6 single expiry", pulse_cnt[3], base + 1);
   endtask

   task automatic t_load_defer();
      logic [31:0] d;
      bus_write(3'd2, 32'd7);
      bus_write(3'd0, mk_ctrl(4'h2, 4'h0, 3'd5, 8'h0C));
      bus_read(3'd2, d);
      check(d == 7, "R8 load on enable", d, 7);
      bus_write(3'd0, mk_ctrl(4'h0, 4'h0, 3'd5, 8'h0C));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_layout();
      t_stamp_rates();
      t_stamp_wrap();
      t_periodic(0, 1, 3);
      t_stop();
      t_periodic(1, 2, 1);
      bus_write(3'd0, 32'h0);
      t_periodic(2, 3, 0);
      bus_write(3'd0, 32'h0);
      t_periodic(3, 0, 9);
      bus_write(3'd0, 32'h0);
      t_oneshot();
      t_load_defer();
      done = 1'b1;
      finish_run();
   end
endmodule